// File: doc/BRIEF.md
# Banked Auto-Increment Read Pointer

This block serves reads from four independent memory banks. Each bank has its own word-address cursor. Software sets a cursor through one 32-bit configuration register. Bits 1:0 of the written value choose the bank. The word address sits just above them, in bits `ADDR_W+1:2`, so the written value reads as a word-aligned byte address whose two spare low bits name the bank. Only the chosen bank's cursor takes the new value.

Each read request names a bank. It returns the word at that bank's cursor, and afterwards that cursor alone moves forward by one word. Streams from different banks can therefore be interleaved without reloading. Software loads a cursor once, before its first read. The cursor then keeps counting, wrapping at the top of the bank, until a new base address is written for that bank.

The configuration register is reached through a valid/ready strobe driven by a two-state handshake machine:
- In `HS_IDLE` a valid request is accepted. This is the *accept* transition to `HS_ACK`.
- `HS_ACK` raises ready for exactly one cycle and then always takes the *retire* transition back to `HS_IDLE`.
- The host drops valid while ready is high.

A separate write port fills the bank memories. Read data arrives one cycle after the request.

Top module: `bank_cursor_unit`

## Requirements
- R1: After reset, every cursor is 0, the configuration register reads back as 0, and `rd_valid` is 0.
- R2: An accepted register write with bits 1:0 = b and bits `ADDR_W+1:2` = A loads A into the cursor of bank b only. The cursors of the other banks keep their values.
- R3: A read request (`rd_en` high, `rd_bank` = b) at a clock edge drives `rd_valid` high and `rd_data` to the word at bank b's cursor, both after that same edge. `rd_valid` is low after an edge with no request.
- R4: After each read of bank b, the cursor of bank b increases by one. Reads of one bank never move another bank's cursor.
- R5: A cursor at `2**ADDR_W-1` wraps to 0 on its next read.
- R6: A cursor holds its value across cycles with no read and no load of its bank. It keeps counting across later reads until a new base is written for that bank.
- R7: When a load and a read of the same bank fall on the same edge, the read returns the word at the newly written address, and the cursor becomes that address plus one.
- R8: `reg_rdata` returns the last value written to the configuration register, all 32 bits, and not the live cursor.
- R9: A request accepted in `HS_IDLE` makes `reg_ready` high for exactly the following cycle (`HS_ACK`), after which it is low again (`HS_IDLE`).
- R10: A fill write (`mem_we`, `mem_bank`, `mem_waddr`, `mem_wdata`) stores the word in that bank, and a later read at that address returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Configuration register request |
| reg_write | input | 1 | 1 = write, 0 = read of the register |
| reg_wdata | input | 32 | Write value: bits 1:0 bank, bits ADDR_W+1:2 word address |
| reg_ready | output | 1 | One-cycle acknowledge of an accepted request |
| reg_rdata | output | 32 | Last value written to the register |
| rd_en | input | 1 | Read request |
| rd_bank | input | 2 | Bank to read |
| rd_valid | output | 1 | Read data valid, one cycle after request |
| rd_data | output | DATA_W | Word read from the bank |
| mem_we | input | 1 | Fill write enable |
| mem_bank | input | 2 | Fill bank |
| mem_waddr | input | ADDR_W | Fill word address |
| mem_wdata | input | DATA_W | Fill word |

## Verification
The bench builds the block with `ADDR_W = 3`, giving eight words per bank. This size lets it load every base address in every bank and then read nine times past each one, so every cursor passes through its wrap point from every start. The memories are filled with words that encode bank and address. Because of this, each returned word identifies which cursor was used and its value, and any cross-bank disturbance shows up directly. Same-edge load/read collisions, idle gaps and register readback after reads are exercised on this small configuration.

// File: rtl/bank_cursor_pkg.sv
package bank_cursor_pkg;
    localparam int REG_W     = 32;
    localparam int SEL_W     = 2;
    localparam int NUM_BANKS = 1 << SEL_W;

    typedef enum logic {
        HS_IDLE = 1'b0,
        HS_ACK  = 1'b1
    } hs_state_e;
endpackage

// File: rtl/cursor_cfg_port.sv
module cursor_cfg_port
    import bank_cursor_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic              reg_ready,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              ld_en,
    output logic [SEL_W-1:0]  ld_bank,
    output logic [ADDR_W-1:0] ld_addr
);
    hs_state_e           state_q, state_d;
    logic [REG_W-1:0]    cfg_q;
    logic                accept;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    // transitions: accept (IDLE->ACK), retire (ACK->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE: if (reg_valid) state_d = HS_ACK;
            HS_ACK:  state_d = HS_IDLE;
            default: state_d = HS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept    = 1'b0;
        reg_ready = 1'b0;
        unique case (state_q)
            HS_IDLE: accept    = reg_valid;
            HS_ACK:  reg_ready = 1'b1;
            default: ;
        endcase
    end

    assign ld_en   = accept && reg_write;
    assign ld_bank = reg_wdata[SEL_W-1:0];
    assign ld_addr = reg_wdata[SEL_W+ADDR_W-1:SEL_W];

    always_ff @(posedge clk) begin
        if (!rst_n)     cfg_q <= '0;
        else if (ld_en) cfg_q <= reg_wdata;
    end

    assign reg_rdata = cfg_q;

    assert_ready_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_ready |=> !reg_ready);
    assert_ready_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_ready && reg_valid) |=> reg_ready);
    assert_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_ready && reg_valid && reg_write) |=> (reg_rdata == $past(reg_wdata)));
endmodule

// File: rtl/cursor_bank_slice.sv
module cursor_bank_slice #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_hit,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              rd_hit,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] dout
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] eff_addr;

    // a load on the same edge overrides the held cursor
    assign eff_addr = ld_hit ? ld_addr : ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (rd_hit) ptr_q <= ADDR_W'(eff_addr + 1'b1);
        else if (ld_hit) ptr_q <= ld_addr;
    end

    always_ff @(posedge clk) begin
        if (wr_en)  mem[wr_addr] <= wr_data;
        if (rd_hit) dout <= mem[eff_addr];
    end

    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !ld_hit) |=> (ptr_q == ADDR_W'($past(ptr_q) + 1'b1)));
    assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_hit && !rd_hit) |=> (ptr_q == $past(ld_addr)));
    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_hit && !rd_hit) |=> $stable(ptr_q));
    assert_collision_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_hit && rd_hit) |=> (ptr_q == ADDR_W'($past(ld_addr) + 1'b1)));
endmodule

// File: rtl/bank_cursor_unit.sv
module bank_cursor_unit
    import bank_cursor_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [31:0]       reg_wdata,
    output logic              reg_ready,
    output logic [31:0]       reg_rdata,
    input  logic              rd_en,
    input  logic [1:0]        rd_bank,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              mem_we,
    input  logic [1:0]        mem_bank,
    input  logic [ADDR_W-1:0] mem_waddr,
    input  logic [DATA_W-1:0] mem_wdata
);
    logic              ld_en;
    logic [SEL_W-1:0]  ld_bank;
    logic [ADDR_W-1:0] ld_addr;
    logic [DATA_W-1:0] bank_dout [NUM_BANKS];
    logic [SEL_W-1:0]  rd_bank_q;
    logic              rd_valid_q;

    cursor_cfg_port #(.ADDR_W(ADDR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_wdata (reg_wdata),
        .reg_ready (reg_ready),
        .reg_rdata (reg_rdata),
        .ld_en     (ld_en),
        .ld_bank   (ld_bank),
        .ld_addr   (ld_addr)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        cursor_bank_slice #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .ld_hit  (ld_en && (ld_bank == SEL_W'(b))),
            .ld_addr (ld_addr),
            .rd_hit  (rd_en && (rd_bank == SEL_W'(b))),
            .wr_en   (mem_we && (mem_bank == SEL_W'(b))),
            .wr_addr (mem_waddr),
            .wr_data (mem_wdata),
            .dout    (bank_dout[b])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_bank_q  <= '0;
        end else begin
            rd_valid_q <= rd_en;
            if (rd_en) rd_bank_q <= rd_bank;
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = bank_dout[rd_bank_q];

    assert_rd_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    assert_rd_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
endmodule

// File: tb/sim_bank_cursor_unit.sv
`timescale 1ns/1ps
module sim_bank_cursor_unit;
    localparam int AW = 3;
    localparam int DW = 32;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_valid = 1'b0, reg_write = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic          reg_ready;
    logic [31:0]   reg_rdata;
    logic          rd_en = 1'b0;
    logic [1:0]    rd_bank = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          mem_we = 1'b0;
    logic [1:0]    mem_bank = '0;
    logic [AW-1:0] mem_waddr = '0;
    logic [DW-1:0] mem_wdata = '0;

    int errors = 0;
    int checks = 0;
    logic [DW-1:0] mdl [4][DEPTH];
    int            eptr [4];
    logic [31:0]   last_cfg;

    always #4 clk = ~clk;

    bank_cursor_unit #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_wdata(reg_wdata),
        .reg_ready(reg_ready), .reg_rdata(reg_rdata),
        .rd_en(rd_en), .rd_bank(rd_bank), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_we(mem_we), .mem_bank(mem_bank), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    function automatic logic [31:0] pat(int b, int a);
        return {8'h5A, 8'(b), 8'(a), 8'hC3};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_xfer(input logic wr, input logic [31:0] wd, output logic [31:0] rd);
        reg_valid = 1'b1; reg_write = wr; reg_wdata = wd;
        @(negedge clk);
        check("R9 ready after accept", 32'(reg_ready), 32'd1);
        rd = reg_rdata;
        reg_valid = 1'b0; reg_write = 1'b0;
        @(negedge clk);
        check("R9 ready drops", 32'(reg_ready), 32'd0);
        if (wr) begin
            eptr[wd[1:0]] = int'(wd[AW+1:2]);
            last_cfg = wd;
        end
    endtask

    task automatic load(int b, int a);
        logic [31:0] dummy;
        reg_xfer(1'b1, 32'((a << 2) | b) | 32'hF000_0000, dummy);
    endtask

    task automatic do_read(int b, string req);
        rd_en = 1'b1; rd_bank = 2'(b);
        @(negedge clk);
        rd_en = 1'b0;
        check(req, 32'(rd_valid), 32'd1);
        check(req, rd_data, mdl[b][eptr[b]]);
        eptr[b] = (eptr[b] + 1) % DEPTH;
    endtask

    initial begin
        #(8ns * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] rb;
        for (int b = 0; b < 4; b++) eptr[b] = 0;
        last_cfg = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rd_valid after reset", 32'(rd_valid), 32'd0);
        reg_xfer(1'b0, '0, rb);
        check("R1 register reset value", rb, 32'd0);

        // R10: fill every bank through the fill port
        for (int b = 0; b < 4; b++)
            for (int a = 0; a < DEPTH; a++) begin
                mem_we = 1'b1; mem_bank = 2'(b); mem_waddr = AW'(a); mem_wdata = pat(b, a);
                mdl[b][a] = pat(b, a);
                @(negedge clk);
            end
        mem_we = 1'b0;

        // R1/R3: first read of each bank uses cursor 0
        for (int b = 0; b < 4; b++) do_read(b, "R1 R3 cursor zero after reset");
        @(negedge clk);
        check("R3 rd_valid low when idle", 32'(rd_valid), 32'd0);

        // R4/R5: every base in every bank, nine reads each (crosses wrap)
        for (int b = 0; b < 4; b++)
            for (int a = 0; a < DEPTH; a++) begin
                load(b, a);
                for (int k = 0; k < DEPTH + 1; k++) do_read(b, "R4 R5 increment and wrap");
            end

        // R2/R4: load all banks, then interleave reads
        for (int b = 0; b < 4; b++) load(b, (b * 2 + 1) % DEPTH);
        for (int r = 0; r < 3; r++)
            for (int b = 3; b >= 0; b--) do_read(b, "R2 R4 independent cursors");
        load(2, 6);
        do_read(0, "R2 load leaves other bank");
        do_read(2, "R2 loaded bank");

        // R6: hold over idle cycles, continue until reload
        repeat (7) @(negedge clk);
        for (int b = 0; b < 4; b++) do_read(b, "R6 hold across idle");
        load(1, 7);
        do_read(1, "R6 reload restarts");

        // R7: load and read of the same bank on one edge
        for (int b = 0; b < 4; b++) begin
            int a;
            a = (b * 3 + 2) % DEPTH;
            reg_valid = 1'b1; reg_write = 1'b1; reg_wdata = 32'((a << 2) | b);
            rd_en = 1'b1; rd_bank = 2'(b);
            @(negedge clk);
            rd_en = 1'b0; reg_valid = 1'b0; reg_write = 1'b0;
            check("R7 collision data", rd_data, mdl[b][a]);
            check("R9 ready on collision", 32'(reg_ready), 32'd1);
            last_cfg = 32'((a << 2) | b);
            eptr[b] = (a + 1) % DEPTH;
            @(negedge clk);
            do_read(b, "R7 cursor after collision");
        end

        // R8: readback returns last written value, not cursor
        load(3, 5);
        reg_xfer(1'b1, 32'hABCD_1237, rb);
        for (int k = 0; k < 3; k++) do_read(3, "R8 reads before readback");
        reg_xfer(1'b0, '0, rb);
        check("R8 readback full value", rb, 32'hABCD_1237);
        check("R8 readback matches model", rb, last_cfg);

        // R10: overwrite one word and read it back
        mem_we = 1'b1; mem_bank = 2'd2; mem_waddr = AW'(5); mem_wdata = 32'hFEED_0055;
        mdl[2][5] = 32'hFEED_0055;
        @(negedge clk);
        mem_we = 1'b0;
        load(2, 5);
        do_read(2, "R10 fill word returned");
        do_read(2, "R10 neighbour unchanged");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule